// File: doc/BRIEF.md
# ADC Conversion Trigger Controller

This block decides the moment at which an analog-to-digital conversion begins. It holds a small configuration word made of a three-bit mode field and a trigger-type bit. It watches two request sources: an external start pin and one output of the on-chip programmable logic. It emits a single-cycle start pulse toward the converter and takes back a single-cycle done pulse. The converter itself, channel selection, reference selection and result storage are outside this block.

The pin is asynchronous and goes through a two-flop synchronizer. The logic-array output is already on the core clock and passes through one retiming flop. The trigger-type bit applies to both sources. When it is clear, a low level requests conversions. When it is set, each rising edge requests one conversion. While a conversion is outstanding, new requests are dropped. In continuous mode the block restarts by itself after every done. In single mode it writes the mode field back to idle once the conversion completes.

Top module: `adc_trig_ctrl`

## Requirements
- R1: While reset is high and on the cycle after it, `conv_start_o` is 0, `mode_o` is 3'b000 and `edge_sel_o` is 0.
- R2: Mode 3'b011 is single mode, started by the pin. When a done pulse arrives for the conversion in progress, `mode_o` reads 3'b000 on the following cycle, unless a configuration write lands on the same edge (the write wins).
- R3: With `edge_sel_o` = 0, a low level on `conv_pin_i` requests a conversion. `conv_start_o` goes high in the cycle after the third rising clock edge that follows the pin falling.
- R4: With `edge_sel_o` = 1, a pin held low requests nothing. Each rising edge of the pin gives exactly one start pulse, in the cycle after the third clock edge that follows the pin rising.
- R5: Mode 3'b101 takes its trigger from `logic_trig_i` through one retiming flop. With the edge type, the start pulse appears in the cycle after the second clock edge that follows the input rising. With the level type, holding the input low produces repeated conversions.
- R6: Mode 3'b100 is continuous mode. Its first conversion is requested by the pin. After each done pulse for an outstanding conversion, the next start pulse is issued in the very next cycle, for as long as the mode field stays 3'b100.
- R7: After a start pulse, and until a done pulse arrives, any further pin or logic trigger is ignored and produces no start pulse.
- R8: Mode 3'b000 and every code other than 3'b011, 3'b100 and 3'b101 produce no start pulses. In a mode that uses one source, a request on the other source is ignored.
- R9: `conv_start_o` is never high for two cycles in a row, except for a continuous restart caused by a done pulse in the same cycle as the start.
- R10: A done pulse while no conversion is outstanding is ignored. The mode field is kept and no start pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_mode | input | 3 | Mode value written when `cfg_we` is high |
| cfg_edge | input | 1 | Trigger type written when `cfg_we` is high: 0 low level, 1 rising edge |
| conv_pin_i | input | 1 | Asynchronous external conversion-start pin |
| logic_trig_i | input | 1 | Trigger from the programmable logic, core-clock domain |
| conv_done_i | input | 1 | One-cycle pulse from the converter when a conversion ends |
| conv_start_o | output | 1 | One-cycle pulse that starts a conversion |
| mode_o | output | 3 | Current mode field, including the hardware clear after single mode |
| edge_sel_o | output | 1 | Current trigger-type bit |

## Verification
A busy flag left stuck set shows up at the ports: the next trigger, or the next continuous restart, never produces a pulse on `conv_start_o`. A busy flag that is lost shows up as a second pulse from a trigger that arrives during a conversion. A wrong number of synchronizer or retiming stages moves the start pulse by a whole cycle. The bench therefore samples the pulse at the exact cycle the requirements give, for both the pin and the logic path. A missed hardware clear appears on `mode_o` one cycle after the done pulse, and a missed continuous restart appears as a silent `conv_start_o` in that same cycle.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_IDLE   = 3'b000;
    localparam logic [MODE_W-1:0] MODE_SINGLE = 3'b011;
    localparam logic [MODE_W-1:0] MODE_CONT   = 3'b100;
    localparam logic [MODE_W-1:0] MODE_LOGIC  = 3'b101;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_PIN   = 2'd1,
        SRC_LOGIC = 2'd2
    } trig_src_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              edge_sel;
    } trig_cfg_t;

    function automatic trig_src_e mode_to_src(input logic [MODE_W-1:0] m);
        case (m)
            MODE_SINGLE, MODE_CONT: return SRC_PIN;
            MODE_LOGIC:             return SRC_LOGIC;
            default:                return SRC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/adc_trig_cond.sv
// Resynchronizes one trigger input and turns it into a request:
// low level when edge_sel_i = 0, single-cycle rising edge when 1.
module adc_trig_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    input  logic edge_sel_i,
    output logic req_o
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   sync_w;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= 1'b1;
                else     chain_q <= raw_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i};
            end
        end
    endgenerate

    assign sync_w = chain_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= sync_w;
    end

    always_comb begin
        if (edge_sel_i) req_o = sync_w & ~prev_q;
        else            req_o = ~sync_w;
    end
endmodule

// File: rtl/adc_trig_seq.sv
// Holds the configuration word, tracks an outstanding conversion
// and issues start pulses.
module adc_trig_seq
    import adc_trig_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_we,
    input  trig_cfg_t cfg_i,
    input  logic      pin_req_i,
    input  logic      logic_req_i,
    input  logic      done_i,
    output trig_cfg_t cfg_o,
    output logic      start_o
);
    trig_cfg_t cfg_q;
    logic      busy_q;
    logic      start_q;
    logic      req_w;
    logic      restart_w;
    logic      finish_w;
    logic      start_d;

    always_comb begin
        case (mode_to_src(cfg_q.mode))
            SRC_PIN:   req_w = pin_req_i;
            SRC_LOGIC: req_w = logic_req_i;
            default:   req_w = 1'b0;
        endcase
        finish_w  = busy_q & done_i;
        restart_w = finish_w & (cfg_q.mode == MODE_CONT);
        start_d   = (~busy_q & req_w) | restart_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            busy_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= start_d;
            if (start_d)       busy_q <= 1'b1;
            else if (finish_w) busy_q <= 1'b0;
            if (cfg_we)
                cfg_q <= cfg_i;
            else if (finish_w && cfg_q.mode == MODE_SINGLE)
                cfg_q.mode <= MODE_IDLE;
        end
    end

    assign cfg_o   = cfg_q;
    assign start_o = start_q;
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
    import adc_trig_pkg::*;
#(
    parameter int PIN_SYNC_STAGES   = 2,
    parameter int LOGIC_SYNC_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              cfg_edge,
    input  logic              conv_pin_i,
    input  logic              logic_trig_i,
    input  logic              conv_done_i,
    output logic              conv_start_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              edge_sel_o
);
    trig_cfg_t cfg_wr;
    trig_cfg_t cfg_cur;
    logic      pin_req;
    logic      logic_req;

    assign cfg_wr.mode     = cfg_mode;
    assign cfg_wr.edge_sel = cfg_edge;

    adc_trig_cond #(.SYNC_STAGES(PIN_SYNC_STAGES)) pin_cond_i (
        .clk        (clk),
        .rst        (rst),
        .raw_i      (conv_pin_i),
        .edge_sel_i (cfg_cur.edge_sel),
        .req_o      (pin_req)
    );

    adc_trig_cond #(.SYNC_STAGES(LOGIC_SYNC_STAGES)) logic_cond_i (
        .clk        (clk),
        .rst        (rst),
        .raw_i      (logic_trig_i),
        .edge_sel_i (cfg_cur.edge_sel),
        .req_o      (logic_req)
    );

    adc_trig_seq seq_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_i       (cfg_wr),
        .pin_req_i   (pin_req),
        .logic_req_i (logic_req),
        .done_i      (conv_done_i),
        .cfg_o       (cfg_cur),
        .start_o     (conv_start_o)
    );

    assign mode_o     = cfg_cur.mode;
    assign edge_sel_o = cfg_cur.edge_sel;
endmodule

// File: rtl/adc_trig_ctrl_chk.sv
module adc_trig_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_we,
    input logic       conv_done_i,
    input logic       conv_start_o,
    input logic [2:0] mode_o,
    input logic       edge_sel_o
);
    // Outstanding-conversion tracker built from port activity only.
    logic busy_m;
    always_ff @(posedge clk) begin
        if (rst)               busy_m <= 1'b0;
        else if (conv_done_i)  busy_m <= 1'b0;
        else if (conv_start_o) busy_m <= 1'b1;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!conv_start_o && mode_o == 3'b000 && !edge_sel_o));

    assert_single_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (busy_m && conv_done_i && mode_o == 3'b011 && !cfg_we) |=> (mode_o == 3'b000));

    assert_cont_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (busy_m && conv_done_i && mode_o == 3'b100) |=> conv_start_o);

    assert_busy_block_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_m && !conv_done_i) |=> !conv_start_o);

    assert_active_mode_R8: assert property (@(posedge clk) disable iff (rst)
        conv_start_o |-> ($past(mode_o) == 3'b011 || $past(mode_o) == 3'b100
                          || $past(mode_o) == 3'b101));

    assert_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        (conv_start_o && !conv_done_i) |=> !conv_start_o);
endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .conv_done_i  (conv_done_i),
    .conv_start_o (conv_start_o),
    .mode_o       (mode_o),
    .edge_sel_o   (edge_sel_o)
);

// File: tb/adc_trig_ctrl_tb_top.sv
module adc_trig_ctrl_tb_top;
    localparam int DONE_LAT = 3;
    localparam int NVEC     = 11;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_mode = 3'b000;
    logic       cfg_edge = 1'b0;
    logic       conv_pin_i = 1'b1;
    logic       logic_trig_i = 1'b1;
    logic       conv_done_i;
    logic       conv_start_o;
    logic [2:0] mode_o;
    logic       edge_sel_o;

    logic auto_done = 1'b0;
    logic auto_pulse = 1'b0;
    logic man_done = 1'b0;
    int   start_cnt = 0;
    int   n_tests = 0;
    int   n_fail = 0;

    assign conv_done_i = auto_pulse | man_done;

    always #2 clk = ~clk;  // 250 MHz

    adc_trig_ctrl dut_i (
        .clk          (clk),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_mode     (cfg_mode),
        .cfg_edge     (cfg_edge),
        .conv_pin_i   (conv_pin_i),
        .logic_trig_i (logic_trig_i),
        .conv_done_i  (conv_done_i),
        .conv_start_o (conv_start_o),
        .mode_o       (mode_o),
        .edge_sel_o   (edge_sel_o)
    );

    // Start counter and automatic converter model (done DONE_LAT cycles after start).
    initial begin
        int dcnt;
        dcnt = 0;
        forever begin
            @(negedge clk);
            auto_pulse = 1'b0;
            if (dcnt > 0) begin
                dcnt = dcnt - 1;
                if (dcnt == 0) auto_pulse = 1'b1;
            end
            if (conv_start_o) begin
                start_cnt = start_cnt + 1;
                if (auto_done) dcnt = DONE_LAT - 1;
            end
        end
    end

    // Fields: mode[11:9] edge[8] target[7] (0 pin, 1 logic) kind[6:5]
    // (0 none, 1 hold low, 2 short low pulse) exp_starts[4:3] exp_mode[2:0]
    localparam logic [11:0] VEC [NVEC] = '{
        {3'b000, 1'b0, 1'b0, 2'd1, 2'd0, 3'b000},  // R8 idle
        {3'b011, 1'b0, 1'b0, 2'd1, 2'd1, 3'b000},  // R2 R3 level single
        {3'b011, 1'b1, 1'b0, 2'd2, 2'd1, 3'b000},  // R2 R4 edge single
        {3'b011, 1'b1, 1'b0, 2'd1, 2'd0, 3'b011},  // R4 low, no edge
        {3'b101, 1'b1, 1'b1, 2'd2, 2'd1, 3'b101},  // R5 logic edge
        {3'b101, 1'b1, 1'b1, 2'd1, 2'd0, 3'b101},  // R5 logic low, edge type
        {3'b110, 1'b0, 1'b0, 2'd1, 2'd0, 3'b110},  // R8 invalid code
        {3'b111, 1'b0, 1'b1, 2'd1, 2'd0, 3'b111},  // R8 invalid code
        {3'b001, 1'b0, 1'b0, 2'd1, 2'd0, 3'b001},  // R8 invalid code
        {3'b101, 1'b0, 1'b0, 2'd1, 2'd0, 3'b101},  // R8 pin in logic mode
        {3'b011, 1'b0, 1'b1, 2'd1, 2'd0, 3'b011}   // R8 logic in pin mode
    };

    task automatic chk(input string req, input int act, input int exp);
        n_tests = n_tests + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [2:0] m, input logic e);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = m; cfg_edge = e;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        man_done = 1'b1;
        @(negedge clk);
        man_done = 1'b0;
    endtask

    task automatic drive_src(input logic tgt, input logic v);
        if (tgt) logic_trig_i = v;
        else     conv_pin_i = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests = n_tests + 1;
        n_fail  = n_fail + 1;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int c0;
        wait_cyc(3);
        chk("R1 start in reset", int'(conv_start_o), 0);
        chk("R1 mode in reset", int'(mode_o), 0);
        chk("R1 edge in reset", int'(edge_sel_o), 0);
        rst = 1'b0;
        wait_cyc(1);
        chk("R1 start after reset", int'(conv_start_o), 0);

        // Vector table
        auto_done = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            logic [11:0] v;
            v = VEC[i];
            set_cfg(v[11:9], v[8]);
            start_cnt = 0;
            if (v[6:5] != 2'd0) drive_src(v[7], 1'b0);
            if (v[6:5] == 2'd2) begin
                wait_cyc(4);
                drive_src(v[7], 1'b1);
            end
            wait_cyc(30);
            chk($sformatf("R8 vector %0d start count", i), start_cnt, int'(v[4:3]));
            chk($sformatf("R2 vector %0d mode", i), int'(mode_o), int'(v[2:0]));
            set_cfg(3'b000, 1'b0);
            conv_pin_i = 1'b1; logic_trig_i = 1'b1;
            wait_cyc(10);
        end

        // R3 level latency on the pin
        set_cfg(3'b011, 1'b0);
        conv_pin_i = 1'b0;
        wait_cyc(1); chk("R3 latency edge1", int'(conv_start_o), 0);
        wait_cyc(1); chk("R3 latency edge2", int'(conv_start_o), 0);
        wait_cyc(1); chk("R3 latency edge3", int'(conv_start_o), 1);
        wait_cyc(1); chk("R9 pulse width", int'(conv_start_o), 0);
        wait_cyc(8);
        set_cfg(3'b000, 1'b0); conv_pin_i = 1'b1; wait_cyc(6);

        // R4 edge latency on the pin
        set_cfg(3'b011, 1'b1);
        conv_pin_i = 1'b0; start_cnt = 0;
        wait_cyc(5);
        chk("R4 held low no start", start_cnt, 0);
        conv_pin_i = 1'b1;
        wait_cyc(2); chk("R4 latency edge2", int'(conv_start_o), 0);
        wait_cyc(1); chk("R4 latency edge3", int'(conv_start_o), 1);
        wait_cyc(8);
        set_cfg(3'b000, 1'b0); wait_cyc(6);

        // R5 edge latency on the logic input
        set_cfg(3'b101, 1'b1);
        logic_trig_i = 1'b0; wait_cyc(3);
        logic_trig_i = 1'b1;
        wait_cyc(1); chk("R5 latency edge1", int'(conv_start_o), 0);
        wait_cyc(1); chk("R5 latency edge2", int'(conv_start_o), 1);
        wait_cyc(8);
        set_cfg(3'b000, 1'b0); wait_cyc(6);

        // R5 level repeat on the logic input
        set_cfg(3'b101, 1'b0);
        start_cnt = 0;
        logic_trig_i = 1'b0;
        wait_cyc(30);
        chk("R5 level repeats (>=3)", int'(start_cnt >= 3), 1);
        set_cfg(3'b000, 1'b0); logic_trig_i = 1'b1; wait_cyc(8);

        // Manual converter from here on
        auto_done = 1'b0;
        wait_cyc(4);

        // R7 triggers ignored while busy
        set_cfg(3'b101, 1'b1);
        start_cnt = 0;
        logic_trig_i = 1'b0; wait_cyc(2); logic_trig_i = 1'b1; wait_cyc(4);
        chk("R7 first trigger", start_cnt, 1);
        logic_trig_i = 1'b0; wait_cyc(2); logic_trig_i = 1'b1; wait_cyc(4);
        chk("R7 trigger while busy", start_cnt, 1);
        pulse_done();
        logic_trig_i = 1'b0; wait_cyc(2); logic_trig_i = 1'b1; wait_cyc(4);
        chk("R7 trigger after done", start_cnt, 2);
        pulse_done();
        set_cfg(3'b000, 1'b0); wait_cyc(4);

        // R6 continuous restart
        set_cfg(3'b100, 1'b1);
        start_cnt = 0;
        conv_pin_i = 1'b0; wait_cyc(2); conv_pin_i = 1'b1; wait_cyc(5);
        chk("R6 first start", start_cnt, 1);
        @(negedge clk); man_done = 1'b1;
        @(negedge clk); man_done = 1'b0;
        chk("R6 restart next cycle", int'(conv_start_o), 1);
        wait_cyc(1);
        chk("R9 restart one cycle", int'(conv_start_o), 0);
        wait_cyc(4);
        chk("R6 no extra start", start_cnt, 2);
        set_cfg(3'b000, 1'b0);
        c0 = start_cnt;
        pulse_done();
        wait_cyc(8);
        chk("R6 stops after mode change", start_cnt, c0);
        chk("R6 mode idle", int'(mode_o), 0);

        // R10 stray done
        set_cfg(3'b011, 1'b1);
        start_cnt = 0;
        pulse_done();
        wait_cyc(4);
        chk("R10 mode kept", int'(mode_o), 3);
        chk("R10 no start", start_cnt, 0);

        // R2 configuration write wins over hardware clear
        conv_pin_i = 1'b0; wait_cyc(2); conv_pin_i = 1'b1; wait_cyc(5);
        chk("R2 start before write", start_cnt, 1);
        @(negedge clk);
        man_done = 1'b1; cfg_we = 1'b1; cfg_mode = 3'b101; cfg_edge = 1'b1;
        @(negedge clk);
        man_done = 1'b0; cfg_we = 1'b0;
        chk("R2 write wins", int'(mode_o), 5);
        set_cfg(3'b000, 1'b0);
        wait_cyc(4);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule